// File: doc/BRIEF.md
# Seeded Dual-Polynomial Nonce and Random-Bit Source

This block is the pseudo-random source for an auto-negotiation transmitter. It holds a 7-bit linear-feedback shift register whose contents form the nonce field (used by the far end to spot a looped-back link) and whose top stage supplies the single random bit that the codeword assembler places at codeword bit 49.

The host loads a starting value through an 8-bit seed input and a restart strobe; a restart overrides whatever the register is doing. A runtime select input chooses the feedback polynomial: x^7 + x^6 + 1 when high, x^7 + x^3 + 1 when low. The register moves one step on each cycle its step enable is high. Codeword assembly and the comparison of sent and received nonces are done elsewhere.

Top module: `lfsr_nonce_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the state is 7'b0000001, so `nonce_o` reads 1 and `rand_bit_o` reads 0.
- R2: A cycle with `restart_i` high loads `seed_i[6:0]` into the state, visible on `nonce_o` after that clock edge; `seed_i[7]` is ignored and a restart wins over a simultaneous step.
- R3: A restart whose `seed_i[6:0]` is all zero loads 7'b0000001 instead.
- R4: With `poly_sel_i` high, a step shifts the state up by one (bit k moves to bit k+1) and fills bit 0 with state bit 6 XOR state bit 5 (polynomial x^7 + x^6 + 1).
- R5: With `poly_sel_i` low, a step shifts the state up by one and fills bit 0 with state bit 6 XOR state bit 2 (polynomial x^7 + x^3 + 1).
- R6: With neither `restart_i` nor `step_i` high, the state holds, whatever `seed_i` and `poly_sel_i` do.
- R7: `rand_bit_o` equals state bit 6; `nonce_o` is the state in bits 6:0 with all higher bits zero.
- R8: Changing `poly_sel_i` does not reload the seed or alter the state; the new polynomial applies from the next step.
- R9: Stepping continuously from any nonzero state under either polynomial never reaches zero and returns to the start after exactly 127 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_i | input | SEED_W | Seed; low 7 bits are loaded on restart |
| poly_sel_i | input | 1 | 1: x^7+x^6+1, 0: x^7+x^3+1 |
| restart_i | input | 1 | Reload the seed this cycle |
| step_i | input | 1 | Advance the register one step |
| nonce_o | output | NONCE_W | Current state, zero-extended |
| rand_bit_o | output | 1 | Random bit for codeword bit 49 |

## Verification
The whole state is visible on `nonce_o`, so any wrong bit in the register shows at the ports on the very next falling edge after the clock edge that produced it. A wrong tap choice stays hidden until the tapped bits differ, so the bench loads states such as 0x60 where the two polynomials give different results. A broken lock-up guard or polynomial shows over a full 127-step walk as an early return or an all-zero state.

// File: rtl/lfsr_nonce_gen.sv
module lfsr_nonce_gen #(
  parameter int SEED_W  = 8,
  parameter int NONCE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEED_W-1:0]  seed_i,
  input  logic               poly_sel_i,
  input  logic               restart_i,
  input  logic               step_i,
  output logic [NONCE_W-1:0] nonce_o,
  output logic               rand_bit_o
);
  localparam int DEG = 7;
  localparam int TAP_HI = 5;
  localparam int TAP_LO = 2;
  localparam logic [DEG-1:0] SAFE = DEG'(1);

  logic [DEG-1:0] st;
  logic [DEG-1:0] seed_lo;
  logic           fb;
  logic           unused_seed;

  assign seed_lo     = seed_i[DEG-1:0];
  assign unused_seed = ^seed_i[SEED_W-1:DEG];
  assign fb          = st[DEG-1] ^ (poly_sel_i ? st[TAP_HI] : st[TAP_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= SAFE;
    else if (restart_i)
      st <= (seed_lo == '0) ? SAFE : seed_lo;
    else if (step_i)
      st <= {st[DEG-2:0], fb};
  end

  assign nonce_o    = NONCE_W'(st);
  assign rand_bit_o = st[DEG-1];
endmodule

// File: rtl/lfsr_nonce_gen_chk.sv
module lfsr_nonce_gen_chk #(
  parameter int SEED_W  = 8,
  parameter int NONCE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEED_W-1:0]  seed_i,
  input logic               poly_sel_i,
  input logic               restart_i,
  input logic               step_i,
  input logic [NONCE_W-1:0] nonce_o,
  input logic               rand_bit_o
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && seed_i[6:0] != 7'd0) |=> nonce_o[6:0] == $past(seed_i[6:0]));

  p_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && seed_i[6:0] == 7'd0) |=> nonce_o[6:0] == 7'd1);

  p_step_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && step_i && poly_sel_i) |=>
      nonce_o[6:0] == {$past(nonce_o[5:0]), $past(nonce_o[6] ^ nonce_o[5])});

  p_step_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && step_i && !poly_sel_i) |=>
      nonce_o[6:0] == {$past(nonce_o[5:0]), $past(nonce_o[6] ^ nonce_o[2])});

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !step_i) |=> $stable(nonce_o));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nonce_o >> 7) == '0);

  p_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nonce_o[6:0] != 7'd0);
endmodule

bind lfsr_nonce_gen lfsr_nonce_gen_chk #(.SEED_W(SEED_W), .NONCE_W(NONCE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .poly_sel_i(poly_sel_i),
  .restart_i(restart_i), .step_i(step_i), .nonce_o(nonce_o), .rand_bit_o(rand_bit_o)
);

// File: tb/lfsr_nonce_gen_tb_top.sv
module lfsr_nonce_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] seed = 8'd0;
  logic       sel = 1'b0;
  logic       restart = 1'b0;
  logic       step = 1'b0;
  logic [7:0] nonce;
  logic       rbit;

  int    vec = 0;
  int    bad = 0;
  int    m_st = 1;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_nonce_gen dut_i (
    .clk(clk), .rst_n(rst_n), .seed_i(seed), .poly_sel_i(sel),
    .restart_i(restart), .step_i(step), .nonce_o(nonce), .rand_bit_o(rbit)
  );

  // Reference: exponent of the middle polynomial term picks the tap
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_st <= 1;
    else if (restart) m_st <= ((seed % 128) == 0) ? 1 : (seed % 128);
    else if (step) begin
      int e;
      e = sel ? 6 : 3;
      m_st <= ((m_st * 2) % 128) + (((m_st / 64) + (m_st / (1 << (e - 1)))) % 2);
    end
  end

  task automatic chk(string r, int got, int exp);
    vec++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(req, int'(nonce), m_st);
      chk("R7 rand bit", int'(rbit), (m_st / 64) % 2);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int s);
    seed = 8'(s); restart = 1'b1; tick(); restart = 1'b0;
  endtask

  task automatic period_walk(bit p, string r);
    int early = 0;
    sel = p;
    load(1);
    step = 1'b1;
    for (int i = 1; i <= 127; i++) begin
      tick();
      if (i < 127 && nonce == 8'd1) early++;
    end
    step = 1'b0;
    chk({r, " early returns"}, early, 0);
    chk({r, " back to start"}, int'(nonce), 1);
  endtask

  initial begin
    tick(3);
    chk("R1 nonce in reset", int'(nonce), 1);
    chk("R1 bit in reset", int'(rbit), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 nonce after reset", int'(nonce), 1);
    cmp_en = 1'b1;

    req = "R6"; seed = 8'h33; sel = 1'b1; tick(2); sel = 1'b0; tick(2);

    req = "R2"; seed = 8'hA5; step = 1'b1; restart = 1'b1; tick();
    restart = 1'b0; step = 1'b0;
    chk("R2 bit7 ignored, restart over step", int'(nonce), 8'h25);

    req = "R3"; load(8'h80);
    chk("R3 zero seed guard", int'(nonce), 1);
    load(8'h00);
    chk("R3 all-zero seed", int'(nonce), 1);

    req = "R4"; sel = 1'b1; load(8'h60); step = 1'b1; tick(); step = 1'b0;
    chk("R4 step from 0x60", int'(nonce), 8'h40);
    load(8'h5A); step = 1'b1; tick(20); step = 1'b0;

    req = "R5"; sel = 1'b0; load(8'h60); step = 1'b1; tick(); step = 1'b0;
    chk("R5 step from 0x60", int'(nonce), 8'h41);
    load(8'h37); step = 1'b1; tick(20); step = 1'b0;

    req = "R8"; load(8'h60); sel = 1'b1; tick();
    chk("R8 select change keeps state", int'(nonce), 8'h60);
    step = 1'b1;
    for (int i = 0; i < 24; i++) begin sel = ~sel; tick(); end
    step = 1'b0;

    req = "R6";
    for (int i = 0; i < 8; i++) begin seed = 8'(i * 37); sel = ~sel; tick(); end

    req = "R2"; step = 1'b1; tick(5); seed = 8'h4C; restart = 1'b1; tick();
    restart = 1'b0; tick(4); step = 1'b0;

    req = "R9"; period_walk(1'b1, "R9 poly high");
    period_walk(1'b0, "R9 poly low");

    cmp_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule